// File: doc/BRIEF.md
# Up/Down Thermometer Level Counter

This block keeps a level as a bar of lit bits, the kind of value a meter or progress display shows directly. The bar is a chain of single-bit stages on one clock. Bit 0 is the low end of the bar, and a valid bar has no 0 bit below a 1 bit. The level is the number of lit bits.

When the block counts upward, each stage takes the value of the stage below it, and a 1 enters at bit 0. The bar therefore grows by one on every enabled clock while the data input is high. When it counts downward, the connections between stages point the other way, and a 0 enters at the top. The bar then shrinks by one on every enabled clock while the data input is low.

A set/reset direction flip-flop picks which set of stage-to-stage connections is active. It is set by an up button and cleared by a down button. A synchronous clear empties the bar, and a step enable freezes it.

Top module: `thermoLevelCounter`

## Requirements
- R1: While `rstN` is low, `bar` is all zeros and `dirUp` is 1. The reset acts at once, without waiting for a clock.
- R2: With `dirUp`=1, `stepEn`=1, `dataIn`=1 and `clear`=0, each rising edge makes `bar` become `{bar[LEVELS-2:0], 1'b1}`, so the level goes up by one.
- R3: With `dirUp`=1 and `dataIn`=0, `bar` keeps its value across the edge.
- R4: With `dirUp`=0, `stepEn`=1, `dataIn`=0 and `clear`=0, each rising edge makes `bar` become `{1'b0, bar[LEVELS-1:1]}`, so the level goes down by one.
- R5: With `dirUp`=0 and `dataIn`=1, `bar` keeps its value across the edge.
- R6: An edge with `upBtn`=1 and `downBtn`=0 makes `dirUp` 1. An edge with `downBtn`=1 and `upBtn`=0 makes it 0. With both buttons high or both low, `dirUp` holds. A step on the same edge as a button press still uses the old direction.
- R7: An edge with `clear`=1 makes `bar` all zeros, whatever `stepEn`, `dataIn` and the direction are. `clear` leaves `dirUp` unchanged.
- R8: An edge with `stepEn`=0 and `clear`=0 leaves `bar` unchanged. The buttons still act on `dirUp` during such an edge.
- R9: A full bar stays full under further up steps, and an empty bar stays empty under further down steps.
- R10: After every edge, `bar` is a valid thermometer code: `bar & (bar+1)` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all stages |
| rstN | input | 1 | Asynchronous active-low reset |
| stepEn | input | 1 | Step enable; the bar is frozen when this is low |
| dataIn | input | 1 | Level data: high grows the bar in up mode, low shrinks it in down mode |
| clear | input | 1 | Synchronous active-high clear of the bar |
| upBtn | input | 1 | Sets the direction flip-flop to up |
| downBtn | input | 1 | Clears the direction flip-flop to down |
| bar | output | LEVELS | Thermometer-coded level, bit 0 at the low end |
| dirUp | output | 1 | Current direction, 1 for up |

## Verification
The bench sweeps every start level from empty to full, in both directions, with every combination of enable, data and clear.

- If a design shifted a 0 in at the low end in up mode, or a 1 in at the top in down mode, the bar would be broken. The per-edge code check would catch it.
- If a design wrapped around or lost its end value at full or empty, the saturation cycles would show a wrong level.
- If the direction change took effect on the same edge as a step, the step on that edge would go the wrong way.
- If both buttons pressed together were not treated as a hold, `dirUp` would change where it should not.
- If `clear` were gated by the enable, the clear would be missed on edges where `stepEn` is low.

// File: rtl/levelPkg.sv
package levelPkg;

  // Strobes from the control path to the stage chain, one set per clock.
  typedef struct packed {
    logic clearAll;  // empty the bar this edge
    logic moveUp;    // take value from the stage below
    logic moveDown;  // take value from the stage above
  } levelStrobes_t;

endpackage

// File: rtl/levelCtrl.sv
module levelCtrl
  import levelPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          stepEn,
  input  logic          dataIn,
  input  logic          clear,
  input  logic          upBtn,
  input  logic          downBtn,
  output logic          dirUp,
  output levelStrobes_t strobes
);

  logic setDir;
  logic resetDir;

  // Set/reset direction flip-flop; simultaneous presses hold.
  assign setDir   = upBtn & ~downBtn;
  assign resetDir = downBtn & ~upBtn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirUp <= 1'b1;
    end else if (setDir) begin
      dirUp <= 1'b1;
    end else if (resetDir) begin
      dirUp <= 1'b0;
    end
  end

  // Clear wins over stepping; stepping needs the enable and a matching data level.
  always_comb begin
    strobes.clearAll = clear;
    strobes.moveUp   = ~clear & stepEn & dirUp & dataIn;
    strobes.moveDown = ~clear & stepEn & ~dirUp & ~dataIn;
  end

endmodule

// File: rtl/levelStage.sv
module levelStage
  import levelPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  levelStrobes_t strobes,
  input  logic          fromBelow,
  input  logic          fromAbove,
  output logic          q
);

  logic upPath;
  logic downPath;
  logic holdPath;
  logic nextQ;

  // Gated links: exactly one source reaches the flop input.
  always_comb begin
    upPath   = strobes.moveUp & fromBelow;
    downPath = strobes.moveDown & fromAbove;
    holdPath = ~strobes.moveUp & ~strobes.moveDown & q;
    nextQ    = ~strobes.clearAll & (upPath | downPath | holdPath);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= 1'b0;
    end else begin
      q <= nextQ;
    end
  end

endmodule

// File: rtl/levelChain.sv
module levelChain
  import levelPkg::*;
#(
  parameter int LEVELS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  levelStrobes_t     strobes,
  output logic [LEVELS-1:0] bar
);

  localparam int TOP = LEVELS - 1;

  for (genvar g = 0; g < LEVELS; g++) begin : gStage
    logic belowBit;
    logic aboveBit;

    // The low end is fed a constant 1 and the top end a constant 0.
    if (g == 0) begin : gLowEnd
      assign belowBit = 1'b1;
    end else begin : gLowLink
      assign belowBit = bar[g-1];
    end

    if (g == TOP) begin : gHighEnd
      assign aboveBit = 1'b0;
    end else begin : gHighLink
      assign aboveBit = bar[g+1];
    end

    levelStage uStage (
      .clk       (clk),
      .rstN      (rstN),
      .strobes   (strobes),
      .fromBelow (belowBit),
      .fromAbove (aboveBit),
      .q         (bar[g])
    );
  end

endmodule

// File: rtl/thermoLevelCounter.sv
module thermoLevelCounter
  import levelPkg::*;
#(
  parameter int LEVELS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic              dataIn,
  input  logic              clear,
  input  logic              upBtn,
  input  logic              downBtn,
  output logic [LEVELS-1:0] bar,
  output logic              dirUp
);

  levelStrobes_t strobes;

  levelCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .stepEn  (stepEn),
    .dataIn  (dataIn),
    .clear   (clear),
    .upBtn   (upBtn),
    .downBtn (downBtn),
    .dirUp   (dirUp),
    .strobes (strobes)
  );

  levelChain #(
    .LEVELS (LEVELS)
  ) uChain (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .bar     (bar)
  );

endmodule

// File: rtl/thermoLevelChecker.sv
module thermoLevelChecker #(
  parameter int LEVELS = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              stepEn,
  input logic              dataIn,
  input logic              clear,
  input logic              upBtn,
  input logic              downBtn,
  input logic [LEVELS-1:0] bar,
  input logic              dirUp
);

  logic [LEVELS-1:0] barInc;
  assign barInc = bar + {{(LEVELS-1){1'b0}}, 1'b1};

  p_up_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dirUp && stepEn && dataIn && !clear) |=> (bar == $past({bar[LEVELS-2:0], 1'b1})));

  p_up_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dirUp && !dataIn && !clear) |=> $stable(bar));

  p_down_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!dirUp && stepEn && !dataIn && !clear) |=> (bar == $past({1'b0, bar[LEVELS-1:1]})));

  p_down_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!dirUp && dataIn && !clear) |=> $stable(bar));

  p_dir_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (upBtn && !downBtn) |=> dirUp);

  p_dir_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (downBtn && !upBtn) |=> !dirUp);

  p_dir_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (upBtn == downBtn) |=> $stable(dirUp));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (bar == '0));

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && !clear) |=> $stable(bar));

  p_full_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dirUp && stepEn && dataIn && !clear && (&bar)) |=> (&bar));

  p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!dirUp && stepEn && !dataIn && !clear && (bar == '0)) |=> (bar == '0));

  p_thermo_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((bar & barInc) == '0));

endmodule

bind thermoLevelCounter thermoLevelChecker #(
  .LEVELS (LEVELS)
) uLevelChecker (
  .clk     (clk),
  .rstN    (rstN),
  .stepEn  (stepEn),
  .dataIn  (dataIn),
  .clear   (clear),
  .upBtn   (upBtn),
  .downBtn (downBtn),
  .bar     (bar),
  .dirUp   (dirUp)
);

// File: tb/tb_thermoLevelCounter.sv
module tb_thermoLevelCounter;

  localparam int  LEVELS     = 5;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rstN;
  logic              stepEn;
  logic              dataIn;
  logic              clear;
  logic              upBtn;
  logic              downBtn;
  logic [LEVELS-1:0] bar;
  logic              dirUp;

  thermoLevelCounter #(.LEVELS(LEVELS)) dut (
    .clk     (clk),
    .rstN    (rstN),
    .stepEn  (stepEn),
    .dataIn  (dataIn),
    .clear   (clear),
    .upBtn   (upBtn),
    .downBtn (downBtn),
    .bar     (bar),
    .dirUp   (dirUp)
  );

  int   checks   = 0;
  int   failures = 0;
  int   modelLevel;
  logic modelDir;
  bit   finished = 0;

  function automatic logic [LEVELS-1:0] thermo(int lvl);
    return LEVELS'((1 << lvl) - 1);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Inputs are applied just after a falling edge; results are read at the next falling edge.
  task automatic cycle(logic en, logic din, logic clr, logic ub, logic db);
    string tag;
    int    nl;
    logic  nd;
    logic [LEVELS-1:0] inc;
    stepEn  = en;
    dataIn  = din;
    clear   = clr;
    upBtn   = ub;
    downBtn = db;
    nl = modelLevel;
    if (clr) begin
      tag = "R7"; nl = 0;
    end else if (!en) begin
      tag = "R8";
    end else if (modelDir) begin
      if (din) begin
        tag = (modelLevel == LEVELS) ? "R9" : "R2";
        if (modelLevel < LEVELS) nl = modelLevel + 1;
      end else begin
        tag = "R3";
      end
    end else begin
      if (!din) begin
        tag = (modelLevel == 0) ? "R9" : "R4";
        if (modelLevel > 0) nl = modelLevel - 1;
      end else begin
        tag = "R5";
      end
    end
    nd = modelDir;
    if (ub && !db) nd = 1'b1;
    else if (db && !ub) nd = 1'b0;
    @(negedge clk);
    modelLevel = nl;
    modelDir   = nd;
    check(tag, 16'(bar), 16'(thermo(nl)), "bar");
    check("R6", 16'(dirUp), 16'(nd), "dirUp");
    inc = bar + 1'b1;
    check("R10", 16'((bar & inc) == '0), 16'd1, "thermometer");
  endtask

  initial begin
    rstN = 1'b0; stepEn = 1'b0; dataIn = 1'b0; clear = 1'b0;
    upBtn = 1'b0; downBtn = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 16'(bar), 16'd0, "bar in reset");
    check("R1", 16'(dirUp), 16'd1, "dirUp in reset");
    rstN = 1'b1;
    modelLevel = 0;
    modelDir   = 1'b1;
    cycle(0, 0, 0, 0, 0);

    // Sweep: each direction, each start level, each enable/data/clear combination.
    for (int d = 0; d < 2; d++) begin
      for (int lvl = 0; lvl <= LEVELS; lvl++) begin
        for (int combo = 0; combo < 8; combo++) begin
          cycle(0, 0, 1, 1, 0);
          for (int k = 0; k < lvl; k++) cycle(1, 1, 0, 0, 0);
          cycle(0, 0, 0, d[0], !d[0]);
          cycle(combo[2], combo[1], combo[0], 0, 0);
        end
      end
    end

    // R6: both buttons together hold the direction, in either state.
    cycle(0, 0, 0, 0, 1);
    cycle(0, 0, 0, 1, 1);
    cycle(0, 0, 0, 1, 0);
    cycle(0, 0, 0, 1, 1);

    // R6: a step on the edge of a direction press uses the old direction.
    cycle(1, 1, 0, 0, 1);
    cycle(1, 0, 0, 1, 0);
    cycle(1, 1, 0, 0, 0);

    // R9: run past full, then past empty.
    cycle(0, 0, 1, 1, 0);
    for (int k = 0; k < LEVELS + 3; k++) cycle(1, 1, 0, 0, 0);
    cycle(0, 0, 0, 0, 1);
    for (int k = 0; k < LEVELS + 3; k++) cycle(1, 0, 0, 0, 0);

    // R7: clear while disabled and in down mode keeps the direction.
    cycle(0, 0, 0, 1, 0);
    for (int k = 0; k < 3; k++) cycle(1, 1, 0, 0, 0);
    cycle(0, 0, 0, 0, 1);
    cycle(0, 1, 1, 0, 0);

    // R1: reset in mid-run acts without a clock edge.
    cycle(0, 0, 0, 1, 0);
    for (int k = 0; k < 2; k++) cycle(1, 1, 0, 0, 0);
    cycle(0, 0, 0, 0, 1);
    #(CLK_PERIOD/4);
    rstN = 1'b0;
    #1;
    check("R1", 16'(bar), 16'd0, "bar after async reset");
    check("R1", 16'(dirUp), 16'd1, "dirUp after async reset");
    @(negedge clk);
    rstN = 1'b1;
    modelLevel = 0;
    modelDir   = 1'b1;
    cycle(1, 1, 0, 0, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule